// File: doc/BRIEF.md
# Round-Robin Monitor Channel Sequencer

This block walks continuously through a fixed list of twenty measurement steps: two remote-diode temperatures, five supply rails, ten general analog inputs, a main and a standby 3.3 V rail, and the on-die temperature. For each step it starts sixteen conversions on an abstract converter. It times each conversion with a slow tick enable and samples the converter's data when the window ends. It sums the sixteen samples and writes the average into a value store. A host can read that store at any time through a synchronous read port. A one-cycle completion pulse carries the slot number and the averaged value to a downstream limit checker.

A small configuration register holds three bits: bit 0 (start), bit 1 (interrupt enable) and bit 2 (interrupt clear). Monitoring runs while start is 1 and clear is 0. An alarm input from the limit checker is latched and presented as an interrupt when enabled. One pin pair is converted every round both as two analog inputs and as the second remote diode. A mode input decides which of these results is kept.

Top module: `monitor_sequencer`

## Requirements
- R1: After synchronous reset, busy, conv_start, done_valid and irq are 0, and conv_ch is 0.
- R2: When the register holds start=1 and clear=0 while idle, busy and conv_start rise one cycle later, with conv_ch=0 and conv_remote=1.
- R3: Steps run in index order 0 to 19. Steps 0 and 1 are remote-diode steps (conv_remote=1) and step 19 is local temperature. After step 19 the sequence wraps to 0 while start stays 1.
- R4: Each conversion lasts 16 tick pulses on a non-remote step and 48 on a remote step. conv_data is sampled on the tick that ends the window, and the next conv_start follows on the next cycle.
- R5: A stored value is the floor of the sum of the 16 samples divided by 16, so sixteen samples of 255 store 255.
- R6: When a kept step completes, done_valid pulses for exactly one cycle with done_slot and done_value, and the store is written on the same edge. rd_data returns the slot at rd_addr one cycle later; a read of the slot being written in that same cycle returns the old content.
- R7: With pair_diode=0, step 15 writes slot 15 and step 16 writes slot 16, while the result of step 1 is dropped (no pulse, no write). A round therefore yields slots 0, 2, 3 … 19 in that order.
- R8: With pair_diode=1, step 1 writes slot 16, steps 15 and 16 are dropped, and slot 15 keeps its earlier content. A round yields 18 pulses.
- R9: Writing start=0 lets the round in progress finish through step 19. Busy then falls and conv_ch returns to 0.
- R10: A clear bit of 1 while busy drops busy on the next edge and discards the partial sum. The next start begins again at step 0.
- R11: An alarm pulse sets a sticky flag. irq equals that flag gated by the enable bit, one cycle late. A clear bit of 1 resets the flag and holds it reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Slow conversion-time enable |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 3 | {clear, irq enable, start} |
| pair_diode | input | 1 | 1: shared pair used as remote diode 2 |
| alarm_in | input | 1 | Limit-violation pulse from checker |
| conv_start | output | 1 | One-cycle request for a conversion |
| conv_ch | output | 5 | Step index being converted |
| conv_remote | output | 1 | Current step is a remote-diode step |
| conv_data | input | 8 | Converter result |
| busy | output | 1 | Sequencer running |
| done_valid | output | 1 | One-cycle completion pulse |
| done_slot | output | 5 | Slot written |
| done_value | output | 8 | Averaged value written |
| irq | output | 1 | Interrupt output |
| rd_addr | input | 5 | Host read slot |
| rd_data | output | 8 | Host read data (one cycle latency) |

## Verification
The hardest case to reach is a stop request that lands in the middle of a round. The sequencer must then keep running through the remaining steps and only go idle after local temperature. An abort, by contrast, must drop a half-built sum partway through a channel. The stimulus runs a full analog round at a reduced tick rate and wraps into a second round, then aborts it with the clear bit. It then restarts in diode mode, clears start about halfway through that round, and lets the round run out. A per-cycle behavioural model predicts every output and every readable slot throughout. Feeding all-255 data in the diode round exposes a truncated sum. The untouched slot 15 exposes a wrong keep/drop decision.

// File: rtl/mseq_pkg.sv
package mseq_pkg;
  typedef struct packed {
    logic clr;
    logic ien;
    logic start;
  } cfg_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } seq_state_t;
endpackage

// File: rtl/mseq_cfg.sv
module mseq_cfg
  import mseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [2:0] wdata,
  input  logic       alarm,
  output cfg_t       cfg_q,
  output logic       irq
);
  logic flag_q;
  logic flag_d;

  // sticky alarm flag, forced low while clear bit is set
  assign flag_d = cfg_q.clr ? 1'b0 : (flag_q | alarm);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      flag_q <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (wr) cfg_q <= cfg_t'(wdata);
      flag_q <= flag_d;
      irq    <= flag_d & cfg_q.ien;
    end
  end
endmodule

// File: rtl/mseq_timer.sv
module mseq_timer #(
  parameter int TICKS_FAST = 16,
  parameter int TICKS_SLOW = 48
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  input  logic tick,
  input  logic slow,
  output logic win_end
);
  localparam int MAXT = (TICKS_SLOW > TICKS_FAST) ? TICKS_SLOW : TICKS_FAST;
  localparam int CW   = (MAXT > 1) ? $clog2(MAXT) : 1;
  localparam logic [CW-1:0] LIM_FAST = CW'(TICKS_FAST - 1);
  localparam logic [CW-1:0] LIM_SLOW = CW'(TICKS_SLOW - 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] lim;

  assign lim     = slow ? LIM_SLOW : LIM_FAST;
  assign win_end = ~restart & tick & (cnt_q == lim);

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= win_end ? '0 : cnt_q + 1'b1;
  end
endmodule

// File: rtl/mseq_accum.sv
module mseq_accum #(
  parameter int DATA_W    = 8,
  parameter int SAMP_LOG2 = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              sample,
  input  logic [DATA_W-1:0] data,
  output logic              last,
  output logic [DATA_W-1:0] avg
);
  localparam int AW = DATA_W + SAMP_LOG2;

  logic [AW-1:0]        acc_q;
  logic [AW-1:0]        acc_sum;
  logic [SAMP_LOG2-1:0] n_q;

  assign acc_sum = acc_q + AW'(data);
  assign last    = sample & (n_q == '1);
  assign avg     = acc_sum[SAMP_LOG2 +: DATA_W];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc_q <= '0;
      n_q   <= '0;
    end else if (sample) begin
      acc_q <= last ? '0 : acc_sum;
      n_q   <= n_q + 1'b1;
    end
  end
endmodule

// File: rtl/mseq_valfile.sv
module mseq_valfile #(
  parameter int DEPTH  = 20,
  parameter int AW     = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  // read-first single-clock RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/monitor_sequencer.sv
module monitor_sequencer
  import mseq_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int NUM_STEPS    = 20,
  parameter int NUM_REMOTE   = 2,
  parameter int SAMP_LOG2    = 4,
  parameter int TICKS_FAST   = 16,
  parameter int TICKS_SLOW   = 48,
  parameter int DIODE2_STEP  = 1,
  parameter int PAIR_LO_STEP = 15,
  parameter int PAIR_HI_STEP = 16,
  parameter int STEP_W       = $clog2(NUM_STEPS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              cfg_wr,
  input  logic [2:0]        cfg_wdata,
  input  logic              pair_diode,
  input  logic              alarm_in,
  output logic              conv_start,
  output logic [STEP_W-1:0] conv_ch,
  output logic              conv_remote,
  input  logic [DATA_W-1:0] conv_data,
  output logic              busy,
  output logic              done_valid,
  output logic [STEP_W-1:0] done_slot,
  output logic [DATA_W-1:0] done_value,
  output logic              irq,
  input  logic [STEP_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS - 1);
  localparam logic [STEP_W-1:0] REM_LIM   = STEP_W'(NUM_REMOTE);
  localparam logic [STEP_W-1:0] D2_STEP   = STEP_W'(DIODE2_STEP);
  localparam logic [STEP_W-1:0] PLO_STEP  = STEP_W'(PAIR_LO_STEP);
  localparam logic [STEP_W-1:0] PHI_STEP  = STEP_W'(PAIR_HI_STEP);

  cfg_t              cfg_q;
  logic              cfg_ien;
  logic              cfg_clr;
  seq_state_t        state_q;
  logic [STEP_W-1:0] step_q;
  logic              win_end;
  logic              restart;
  logic              sample;
  logic              ch_done;
  logic              samp_last;
  logic [DATA_W-1:0] avg;
  logic              keep;
  logic [STEP_W-1:0] slot;

  assign cfg_ien     = cfg_q.ien;
  assign cfg_clr     = cfg_q.clr;
  assign busy        = (state_q == ST_RUN);
  assign conv_ch     = step_q;
  assign conv_remote = (step_q < REM_LIM);
  assign restart     = ~busy | cfg_q.clr;
  assign sample      = busy & ~cfg_q.clr & win_end;
  assign ch_done     = sample & samp_last;

  mseq_cfg u_cfg (
    .clk   (clk),
    .rst   (rst),
    .wr    (cfg_wr),
    .wdata (cfg_wdata),
    .alarm (alarm_in),
    .cfg_q (cfg_q),
    .irq   (irq)
  );

  mseq_timer #(
    .TICKS_FAST (TICKS_FAST),
    .TICKS_SLOW (TICKS_SLOW)
  ) u_timer (
    .clk     (clk),
    .rst     (rst),
    .restart (restart),
    .tick    (tick),
    .slow    (conv_remote),
    .win_end (win_end)
  );

  mseq_accum #(
    .DATA_W    (DATA_W),
    .SAMP_LOG2 (SAMP_LOG2)
  ) u_accum (
    .clk    (clk),
    .rst    (rst),
    .clear  (restart),
    .sample (sample),
    .data   (conv_data),
    .last   (samp_last),
    .avg    (avg)
  );

  // shared pin pair: mode picks which conversion result survives
  always_comb begin
    keep = 1'b1;
    slot = step_q;
    if (step_q == D2_STEP) begin
      keep = pair_diode;
      slot = PHI_STEP;
    end else if (step_q == PLO_STEP || step_q == PHI_STEP) begin
      keep = ~pair_diode;
    end
  end

  mseq_valfile #(
    .DEPTH  (NUM_STEPS),
    .AW     (STEP_W),
    .DATA_W (DATA_W)
  ) u_vals (
    .clk   (clk),
    .we    (ch_done & keep),
    .waddr (slot),
    .wdata (avg),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      step_q     <= '0;
      conv_start <= 1'b0;
      done_valid <= 1'b0;
      done_slot  <= '0;
      done_value <= '0;
    end else begin
      conv_start <= 1'b0;
      done_valid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          step_q <= '0;
          if (cfg_q.start && !cfg_q.clr) begin
            state_q    <= ST_RUN;
            conv_start <= 1'b1;
          end
        end
        default: begin
          if (cfg_q.clr) begin
            state_q <= ST_IDLE;
            step_q  <= '0;
          end else if (win_end) begin
            if (samp_last) begin
              if (keep) begin
                done_valid <= 1'b1;
                done_slot  <= slot;
                done_value <= avg;
              end
              if (step_q == LAST_STEP) begin
                step_q <= '0;
                if (cfg_q.start) conv_start <= 1'b1;
                else             state_q    <= ST_IDLE;
              end else begin
                step_q     <= step_q + 1'b1;
                conv_start <= 1'b1;
              end
            end else begin
              conv_start <= 1'b1;
            end
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/mseq_checker.sv
module mseq_checker #(
  parameter int STEP_W      = 5,
  parameter int DIODE2_STEP = 1
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              conv_start,
  input logic [STEP_W-1:0] conv_ch,
  input logic              done_valid,
  input logic [STEP_W-1:0] done_slot,
  input logic              irq,
  input logic              cfg_ien,
  input logic              cfg_clr
);
  p_req_while_busy_r2: assert property (@(posedge clk) disable iff (rst)
    conv_start |-> busy);

  p_step_order_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && conv_ch != $past(conv_ch)) |->
      (conv_ch == STEP_W'($past(conv_ch) + 1'b1) || conv_ch == '0));

  p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
    done_valid |=> !done_valid);

  p_no_diode_slot_r7: assert property (@(posedge clk) disable iff (rst)
    done_valid |-> done_slot != STEP_W'(DIODE2_STEP));

  p_idle_home_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> conv_ch == '0);

  p_abort_r10: assert property (@(posedge clk) disable iff (rst)
    (busy && cfg_clr) |=> !busy);

  p_irq_gate_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> ($past(cfg_ien) && !$past(cfg_clr)));
endmodule

bind monitor_sequencer mseq_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .busy       (busy),
  .conv_start (conv_start),
  .conv_ch    (conv_ch),
  .done_valid (done_valid),
  .done_slot  (done_slot),
  .irq        (irq),
  .cfg_ien    (cfg_ien),
  .cfg_clr    (cfg_clr)
);

// File: tb/sim_monitor_sequencer.sv
module sim_monitor_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_wdata = '0;
  logic       pair_diode = 1'b0;
  logic       alarm_in = 1'b0;
  logic       conv_start;
  logic [4:0] conv_ch;
  logic       conv_remote;
  logic [7:0] conv_data = '0;
  logic       busy;
  logic       done_valid;
  logic [4:0] done_slot;
  logic [7:0] done_value;
  logic       irq;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;

  always #10 clk = ~clk;

  monitor_sequencer u0 (
    .clk(clk), .rst(rst), .tick(tick), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .pair_diode(pair_diode), .alarm_in(alarm_in), .conv_start(conv_start),
    .conv_ch(conv_ch), .conv_remote(conv_remote), .conv_data(conv_data),
    .busy(busy), .done_valid(done_valid), .done_slot(done_slot),
    .done_value(done_value), .irq(irq), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference state
  int m_cfg = 0, m_flag = 0, m_irq = 0;
  int m_busy = 0, m_step = 0, m_cnt = 0, m_n = 0, m_sum = 0;
  int m_cs = 0, m_dv = 0, m_dslot = 0, m_dval = 0;
  int m_rd = 0, m_rd_ok = 0;
  int m_mem[20];
  bit m_wr[20];

  task automatic model_step();
    int start, ien, clr, f, lim, slot, keep;
    if (rst) begin
      m_cfg = 0; m_flag = 0; m_irq = 0; m_busy = 0; m_step = 0;
      m_cnt = 0; m_n = 0; m_sum = 0; m_cs = 0; m_dv = 0; m_dslot = 0;
      m_dval = 0; m_rd_ok = 0;
      return;
    end
    start = m_cfg & 1; ien = (m_cfg >> 1) & 1; clr = (m_cfg >> 2) & 1;
    m_rd = m_mem[rd_addr]; m_rd_ok = m_wr[rd_addr];
    f = clr ? 0 : (m_flag | int'(alarm_in));
    m_irq = f & ien; m_flag = f;
    if (cfg_wr) m_cfg = int'(cfg_wdata);
    m_cs = 0; m_dv = 0;
    if (!m_busy) begin
      m_step = 0; m_cnt = 0; m_n = 0; m_sum = 0;
      if (start && !clr) begin m_busy = 1; m_cs = 1; end
    end else if (clr) begin
      m_busy = 0; m_step = 0; m_cnt = 0; m_n = 0; m_sum = 0;
    end else if (tick) begin
      lim = (m_step < 2) ? 48 : 16;
      if (m_cnt == lim - 1) begin
        m_cnt = 0;
        m_sum += int'(conv_data);
        if (m_n == 15) begin
          keep = 1; slot = m_step;
          if (m_step == 1) begin keep = pair_diode; slot = 16; end
          else if (m_step == 15 || m_step == 16) keep = !pair_diode;
          if (keep) begin
            m_dv = 1; m_dslot = slot; m_dval = m_sum / 16;
            m_mem[slot] = m_dval; m_wr[slot] = 1;
          end
          m_sum = 0; m_n = 0;
          if (m_step == 19) begin
            m_step = 0;
            if (start) m_cs = 1; else m_busy = 0;
          end else begin
            m_step++; m_cs = 1;
          end
        end else begin
          m_n++; m_cs = 1;
        end
      end else m_cnt++;
    end
  endtask

  task automatic compare_all();
    check("R4", "conv_start", int'(conv_start), m_cs);
    check("R3", "conv_ch", int'(conv_ch), m_step);
    check("R3", "conv_remote", int'(conv_remote), (m_step < 2) ? 1 : 0);
    check("R9", "busy", int'(busy), m_busy);
    check("R6", "done_valid", int'(done_valid), m_dv);
    if (m_dv) begin
      check("R7", "done_slot", int'(done_slot), m_dslot);
      check("R5", "done_value", int'(done_value), m_dval);
    end
    if (m_rd_ok) check("R6", "rd_data", int'(rd_data), m_rd);
    check("R11", "irq", int'(irq), m_irq);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL R1 watchdog expired actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int saved15;
    int first_dones;
    int diode_dones;
    saved15 = 0; first_dones = 0; diode_dones = 0;
    for (int i = 0; i < 20; i++) begin m_mem[i] = 0; m_wr[i] = 0; end
    for (int c = 0; c < 16100; c++) begin
      @(negedge clk);
      if (c >= 1) compare_all();
      // explicit scenario checks
      if (c == 4) begin
        check("R1", "busy after reset", int'(busy), 0);
        check("R1", "conv_start after reset", int'(conv_start), 0);
        check("R1", "irq after reset", int'(irq), 0);
        check("R1", "conv_ch after reset", int'(conv_ch), 0);
      end
      if (c == 12) begin
        check("R2", "first request", int'(conv_start), 1);
        check("R2", "first step", int'(conv_ch), 0);
        check("R2", "first step remote", int'(conv_remote), 1);
      end
      if (done_valid && c < 9100 && first_dones < 19) begin
        check("R7", "analog round slot order", int'(done_slot),
              (first_dones == 0) ? 0 : first_dones + 1);
        first_dones++;
      end
      if (done_valid && c >= 9220) diode_dones++;
      if (c == 9001) check("R11", "irq after alarm", int'(irq), 1);
      if (c == 9102) begin
        check("R11", "irq cleared", int'(irq), 0);
        check("R10", "abort idles", int'(busy), 0);
      end
      if (c == 9215) saved15 = m_mem[15];
      if (c == 9222) begin
        check("R10", "restart request", int'(conv_start), 1);
        check("R10", "restart at step 0", int'(conv_ch), 0);
      end
      if (c == 12001) check("R11", "irq masked", int'(irq), 0);
      if (c == 12502) check("R11", "irq after enable", int'(irq), 1);
      if (c == 13500) check("R9", "still busy after stop request", int'(busy), 1);
      if (c == 16000) begin
        check("R9", "idle after round", int'(busy), 0);
        check("R9", "home step", int'(conv_ch), 0);
        check("R8", "diode round pulses", diode_dones, 18);
      end
      // stimulus for the next edge
      rst        = (c < 4);
      cfg_wr     = 1'b0;
      alarm_in   = (c == 9000 || c == 12000);
      pair_diode = (c >= 9210);
      tick       = (c < 9200) ? ((c % 4) != 3) : 1'b1;
      conv_data  = (c >= 9215) ? 8'd255 : 8'((c * 37 + c / 32) & 255);
      rd_addr    = 5'(c % 20);
      case (c)
        10:    begin cfg_wr = 1'b1; cfg_wdata = 3'b011; end
        9100:  begin cfg_wr = 1'b1; cfg_wdata = 3'b111; end
        9200:  begin cfg_wr = 1'b1; cfg_wdata = 3'b000; end
        9220:  begin cfg_wr = 1'b1; cfg_wdata = 3'b001; end
        12500: begin cfg_wr = 1'b1; cfg_wdata = 3'b011; end
        13000: begin cfg_wr = 1'b1; cfg_wdata = 3'b010; end
        default: ;
      endcase
      model_step();
    end
    // final readback of the store
    for (int s = 0; s < 20; s++) begin
      if (s == 1) continue;
      @(negedge clk);
      rd_addr = 5'(s);
      @(negedge clk);
      if (s == 15) check("R8", "slot 15 untouched in diode mode", int'(rd_data), saved15);
      else         check("R5", "full-scale average", int'(rd_data), 255);
    end
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule